// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block is the control core of a single DMA channel. Software supplies a start source address, a start destination address and a 16-bit byte count, together with a transfer direction, a unit width and an address mode for each side. A trigger strobe copies these values into working registers. The block then moves data one unit at a time: a read beat at the working source address, then a write beat at the working destination address. After each beat it steps the matching pointer and, after the write, lowers the remaining count.

Each side either increments, holds still, or increments and reloads (wrap). When either side is in wrap mode, the channel runs as a circular buffer. At a zero count it reloads both pointers and the count and starts a new pass by itself. It also reports the half-way and wrap points. The bus is a request/grant/error handshake that carries one address and a size code per beat. Peripheral-paced directions hold a beat back until the peripheral request is high. A bus error latches a stop that only a channel software reset removes. Register decoding and interrupt flag storage sit outside; they see the block only through strobes.

Top module: `dma_chan_seq`

## Requirements
- R1: After the synchronous reset, `run_flag`, `locked`, `rst_busy` and `bus_req` are 0 and `cur_src`, `cur_dst` and `cur_cnt` are 0.
- R2: `trig_set` is accepted only when `cfg_enable` is 1, the channel is idle, `locked` is 0, `rst_busy` is 0 and `soft_rst` is 0. Acceptance loads `cur_src`, `cur_dst` and `cur_cnt` from the start values and sets `run_flag`, and the first read beat uses the source start address. A trigger that is not accepted leaves `run_flag` and `bus_req` at 0.
- R3: Each unit is a read beat (`bus_wr`=0, `bus_addr`=`cur_src`) followed by a write beat (`bus_wr`=1, `bus_addr`=`cur_dst`). A beat completes in a cycle where `bus_req` and `bus_gnt` are both high. `bus_size` gives the unit: 0 byte, 1 half-word, 2 word.
- R4: The unit is 4 bytes when `cfg_dir` is 0 (memory to memory) or 3 (treated as 0). For `cfg_dir` 1 (peripheral to memory) and 2 (memory to peripheral), `cfg_width` sets the unit: 1 is one byte, 2 is two bytes, 0 or 3 is four bytes. Each completed write beat lowers `cur_cnt` by the unit size, stopping at 0.
- R5: Mode code 0 increments a pointer by the unit size, 2 holds it fixed, 1 also holds it fixed, and 3 increments and reloads on wrap. The source pointer steps after a read beat and the destination pointer steps after a write beat.
- R6: Without wrap mode, the write beat that brings the count to 0 ends the run. One cycle later `ev_done` pulses for one cycle and `run_flag` is 0. A trigger accepted with `cfg_len`=0 gives the same `ev_done` with no beats.
- R7: When either mode is 3 and the count reaches 0, both pointers and the count reload from the start values, `ev_wrap` pulses, and `run_flag` stays 1 while the next pass begins.
- R8: In wrap mode, `ev_half` pulses when a write beat leaves a count equal to `cfg_len`/2 (rounded down, nonzero).
- R9: With `cfg_dir`=1 the read beat waits for `periph_req`. With `cfg_dir`=2 the write beat waits for it. The other beats and memory-to-memory mode do not wait.
- R10: When `cfg_enable` goes low, `bus_req` drops in the same cycle and the channel is idle after the next edge, with `run_flag` 0 and no `ev_done`. A unit whose read beat has finished is dropped, so `cur_dst` keeps its value.
- R11: A cycle with `bus_req` and `bus_err` both high gives an `ev_abort` pulse and returns the channel to idle with `locked`=1. Triggers are ignored while locked.
- R12: A `soft_rst` strobe forces the channel idle and clears the pointers, the count and `locked`. After the strobe, `rst_busy` and `enable_clear` are high for exactly RST_CYC cycles, and triggers are ignored during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_dir | input | 2 | Direction: 0 mem-mem, 1 periph-mem, 2 mem-periph |
| cfg_src_mode | input | 2 | Source pointer mode |
| cfg_dst_mode | input | 2 | Destination pointer mode |
| cfg_width | input | 2 | Peripheral unit width code |
| cfg_src_start | input | AW | Programmed source start address |
| cfg_dst_start | input | AW | Programmed destination start address |
| cfg_len | input | CW | Programmed byte count |
| trig_set | input | 1 | Trigger write strobe |
| soft_rst | input | 1 | Channel software reset strobe |
| periph_req | input | 1 | Peripheral request |
| bus_gnt | input | 1 | Bus grant, completes the beat |
| bus_err | input | 1 | Bus error response |
| bus_req | output | 1 | Beat request |
| bus_wr | output | 1 | 1 for a write beat, 0 for a read beat |
| bus_addr | output | AW | Beat address |
| bus_size | output | 2 | Beat size code |
| run_flag | output | 1 | Trigger bit readback, 1 while running |
| locked | output | 1 | Error stop latched |
| rst_busy | output | 1 | Software reset in progress |
| enable_clear | output | 1 | Request to clear the stored enable |
| cur_src | output | AW | Working source address |
| cur_dst | output | AW | Working destination address |
| cur_cnt | output | CW | Remaining byte count |
| ev_done | output | 1 | Transfer done pulse |
| ev_abort | output | 1 | Abort pulse |
| ev_half | output | 1 | Half-way pulse |
| ev_wrap | output | 1 | Wrap pulse |

## Verification
The bench builds the block with 16-bit addresses, a 16-bit count and a three-cycle software reset. This keeps every expected address a short hex constant and lets the reset window be counted cycle by cycle. Short byte counts (0, 3, 4, 5, 6, 8, 16) cover a single-unit run, a count that is not a multiple of the unit, and a wrap pass with a half-way point in a few dozen cycles. The bench holds the grant and peripheral request lines under its own control. This lets it freeze the channel between the read and write beats to show that a disable drops the pending write and that a reset clears a run that is still in progress.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        DIR_M2M = 2'd0,
        DIR_P2M = 2'd1,
        DIR_M2P = 2'd2,
        DIR_RSV = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        AM_INC  = 2'd0,
        AM_RSV  = 2'd1,
        AM_FIX  = 2'd2,
        AM_WRAP = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } st_e;

    typedef struct packed {
        logic done;
        logic abort;
        logic half;
        logic wrap;
    } evt_t;

    function automatic size_e unit_code(input dir_e dir, input logic [1:0] width);
        if (dir == DIR_P2M || dir == DIR_M2P) begin
            case (width)
                2'd1:    return SZ_BYTE;
                2'd2:    return SZ_HALF;
                default: return SZ_WORD;
            endcase
        end
        return SZ_WORD;
    endfunction

    function automatic logic [2:0] code_bytes(input size_e sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic mode_moves(input amode_e m);
        return (m == AM_INC) || (m == AM_WRAP);
    endfunction

endpackage

// File: rtl/dma_addr_walker.sv
module dma_addr_walker
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic          step,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [2:0]    stepb,
    output logic [AW-1:0] addr
);
    localparam int PADW = AW - 3;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            addr <= '0;
        end else if (load) begin
            addr <= base;
        end else if (step && mode_moves(amode_e'(mode))) begin
            addr <= addr + {{PADW{1'b0}}, stepb};
        end
    end

    // R5: a non-moving mode leaves the pointer untouched by a step
    a_r5_fixed_holds: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !clr && !mode_moves(amode_e'(mode))) |=> $stable(addr));

endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic          dec,
    input  logic [CW-1:0] len,
    input  logic [2:0]    stepb,
    output logic [CW-1:0] cnt,
    output logic          last,
    output logic          half_hit
);
    localparam int PADW = CW - 3;

    logic [CW-1:0] step_w;
    logic [CW-1:0] nxt;
    logic [CW-1:0] half_len;

    assign step_w   = {{PADW{1'b0}}, stepb};
    assign nxt      = (cnt > step_w) ? (cnt - step_w) : '0;
    assign half_len = len >> 1;
    assign last     = (nxt == '0);
    assign half_hit = (half_len != '0) && (nxt == half_len);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len;
        end else if (dec) begin
            cnt <= nxt;
        end
    end

    // R4: between loads the remaining count never grows
    a_r4_count_never_grows: assert property (@(posedge clk) disable iff (rst)
        (!load && !clr) |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/dma_rst_timer.sv
module dma_rst_timer #(
    parameter int RST_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(RST_CYC + 1);

    logic [TW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (start) begin
            left <= TW'(RST_CYC);
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign busy = (left != '0);

    // R12: the reset window only opens after a strobe
    a_r12_window_from_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int AW      = 32,
    parameter int CW      = 16,
    parameter int RST_CYC = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_enable,
    input  logic [1:0]    cfg_dir,
    input  logic [1:0]    cfg_src_mode,
    input  logic [1:0]    cfg_dst_mode,
    input  logic [1:0]    cfg_width,
    input  logic [AW-1:0] cfg_src_start,
    input  logic [AW-1:0] cfg_dst_start,
    input  logic [CW-1:0] cfg_len,
    input  logic          trig_set,
    input  logic          soft_rst,
    input  logic          periph_req,
    input  logic          bus_gnt,
    input  logic          bus_err,
    output logic          bus_req,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic          run_flag,
    output logic          locked,
    output logic          rst_busy,
    output logic          enable_clear,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [CW-1:0] cur_cnt,
    output logic          ev_done,
    output logic          ev_abort,
    output logic          ev_half,
    output logic          ev_wrap
);
    st_e        st_q, st_n;
    evt_t       evt_q, evt_n;
    logic       lock_q;
    dir_e       dir;
    size_e      usz;
    logic [2:0] stepb;
    logic       wrap_mode, rd_ok, wr_ok;
    logic       beat_ok, beat_err, rd_done, wr_done;
    logic       accept, start, reload, load, clr;
    logic       cnt_last, cnt_half;

    assign dir       = dir_e'(cfg_dir);
    assign usz       = unit_code(dir, cfg_width);
    assign stepb     = code_bytes(usz);
    assign wrap_mode = (amode_e'(cfg_src_mode) == AM_WRAP) || (amode_e'(cfg_dst_mode) == AM_WRAP);
    assign rd_ok     = (dir != DIR_P2M) || periph_req;
    assign wr_ok     = (dir != DIR_M2P) || periph_req;

    assign bus_req  = cfg_enable && !rst_busy &&
                      (((st_q == ST_RD) && rd_ok) || ((st_q == ST_WR) && wr_ok));
    assign bus_wr   = (st_q == ST_WR);
    assign bus_addr = bus_wr ? cur_dst : cur_src;
    assign bus_size = usz;

    assign beat_ok  = bus_req && bus_gnt && !bus_err;
    assign beat_err = bus_req && bus_err;
    assign rd_done  = beat_ok && (st_q == ST_RD);
    assign wr_done  = beat_ok && (st_q == ST_WR);

    assign accept = trig_set && cfg_enable && (st_q == ST_IDLE) && !lock_q && !rst_busy && !soft_rst;
    assign start  = accept && (cfg_len != '0);
    assign reload = wr_done && cnt_last && wrap_mode;
    assign load   = start || reload;
    assign clr    = soft_rst || rst_busy;

    dma_addr_walker #(.AW(AW)) u_src (
        .clk(clk), .rst(rst), .clr(clr), .load(load), .step(rd_done),
        .mode(cfg_src_mode), .base(cfg_src_start), .stepb(stepb), .addr(cur_src)
    );

    dma_addr_walker #(.AW(AW)) u_dst (
        .clk(clk), .rst(rst), .clr(clr), .load(load), .step(wr_done),
        .mode(cfg_dst_mode), .base(cfg_dst_start), .stepb(stepb), .addr(cur_dst)
    );

    dma_count_unit #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr), .load(load), .dec(wr_done),
        .len(cfg_len), .stepb(stepb), .cnt(cur_cnt), .last(cnt_last), .half_hit(cnt_half)
    );

    dma_rst_timer #(.RST_CYC(RST_CYC)) u_rst (
        .clk(clk), .rst(rst), .start(soft_rst), .busy(rst_busy)
    );

    always_comb begin
        st_n = st_q;
        if (soft_rst || rst_busy) begin
            st_n = ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: if (start) st_n = ST_RD;
                ST_RD: begin
                    if (!cfg_enable || beat_err) st_n = ST_IDLE;
                    else if (rd_done)           st_n = ST_WR;
                end
                ST_WR: begin
                    if (!cfg_enable || beat_err)           st_n = ST_IDLE;
                    else if (wr_done && cnt_last && !wrap_mode) st_n = ST_IDLE;
                    else if (wr_done)                      st_n = ST_RD;
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        evt_n = '0;
        if (!soft_rst && !rst_busy) begin
            evt_n.done  = (wr_done && cnt_last && !wrap_mode) || (accept && (cfg_len == '0));
            evt_n.abort = beat_err;
            evt_n.half  = wr_done && cnt_half && wrap_mode;
            evt_n.wrap  = reload;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            evt_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            evt_q <= evt_n;
            if (soft_rst)      lock_q <= 1'b0;
            else if (beat_err) lock_q <= 1'b1;
        end
    end

    assign run_flag     = (st_q != ST_IDLE);
    assign locked       = lock_q;
    assign enable_clear = rst_busy;
    assign ev_done      = evt_q.done;
    assign ev_abort     = evt_q.abort;
    assign ev_half      = evt_q.half;
    assign ev_wrap      = evt_q.wrap;

    // R10: a disabled channel is idle one cycle later
    a_r10_disable_idles: assert property (@(posedge clk) disable iff (rst)
        (!cfg_enable && !soft_rst) |=> !run_flag);

    // R11: an error response stops the channel and reports the abort
    a_r11_error_stops: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_err && !soft_rst) |=> (ev_abort && !run_flag && locked));

    // R11: while locked no trigger restarts the channel
    a_r11_locked_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (locked && !soft_rst) |=> !run_flag);

    // R6: completion is reported only from idle
    a_r6_done_is_idle: assert property (@(posedge clk) disable iff (rst)
        ev_done |-> !run_flag);

    // R7: a wrap keeps the channel running
    a_r7_wrap_keeps_running: assert property (@(posedge clk) disable iff (rst)
        ev_wrap |-> run_flag);

    // R6: done, abort and wrap never coincide
    a_r6_end_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_done, ev_abort, ev_wrap}));

endmodule

// File: tb/test_dma_chan_seq.sv
`timescale 1ns/1ps
module test_dma_chan_seq;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int RC = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_enable;
    logic [1:0]    cfg_dir, cfg_src_mode, cfg_dst_mode, cfg_width;
    logic [AW-1:0] cfg_src_start, cfg_dst_start;
    logic [CW-1:0] cfg_len;
    logic          trig_set, soft_rst, periph_req, bus_gnt, bus_err;
    logic          bus_req, bus_wr, run_flag, locked, rst_busy, enable_clear;
    logic [AW-1:0] bus_addr, cur_src, cur_dst;
    logic [1:0]    bus_size;
    logic [CW-1:0] cur_cnt;
    logic          ev_done, ev_abort, ev_half, ev_wrap;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dma_chan_seq #(.AW(AW), .CW(CW), .RST_CYC(RC)) i_dma_chan_seq (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_dir(cfg_dir),
        .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode), .cfg_width(cfg_width),
        .cfg_src_start(cfg_src_start), .cfg_dst_start(cfg_dst_start), .cfg_len(cfg_len),
        .trig_set(trig_set), .soft_rst(soft_rst), .periph_req(periph_req),
        .bus_gnt(bus_gnt), .bus_err(bus_err), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .run_flag(run_flag), .locked(locked),
        .rst_busy(rst_busy), .enable_clear(enable_clear), .cur_src(cur_src),
        .cur_dst(cur_dst), .cur_cnt(cur_cnt), .ev_done(ev_done), .ev_abort(ev_abort),
        .ev_half(ev_half), .ev_wrap(ev_wrap)
    );

    typedef struct packed {
        logic [1:0]  dir;
        logic [1:0]  sm;
        logic [1:0]  dm;
        logic [1:0]  wd;
        logic [15:0] src;
        logic [15:0] dst;
        logic [15:0] len;
        logic [7:0]  units;
        logic [15:0] fsrc;
        logic [15:0] fdst;
        logic [1:0]  szc;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 2'd0, 2'd0, 16'h0100, 16'h0200, 16'd16, 8'd4, 16'h0110, 16'h0210, 2'd2},
        '{2'd1, 2'd2, 2'd0, 2'd1, 16'h0040, 16'h0300, 16'd5,  8'd5, 16'h0040, 16'h0305, 2'd0},
        '{2'd2, 2'd0, 2'd2, 2'd2, 16'h0080, 16'h0050, 16'd6,  8'd3, 16'h0086, 16'h0050, 2'd1},
        '{2'd0, 2'd2, 2'd0, 2'd1, 16'h0010, 16'h0020, 16'd8,  8'd2, 16'h0010, 16'h0028, 2'd2},
        '{2'd2, 2'd1, 2'd0, 2'd0, 16'h0030, 16'h0060, 16'd8,  8'd2, 16'h0030, 16'h0068, 2'd2},
        '{2'd1, 2'd0, 2'd0, 2'd3, 16'h0000, 16'h0100, 16'd8,  8'd2, 16'h0008, 16'h0108, 2'd2},
        '{2'd3, 2'd0, 2'd0, 2'd1, 16'h0400, 16'h0500, 16'd4,  8'd1, 16'h0404, 16'h0504, 2'd2},
        '{2'd1, 2'd0, 2'd0, 2'd2, 16'h0010, 16'h0020, 16'd3,  8'd2, 16'h0014, 16'h0024, 2'd1}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] d, input logic [1:0] sm, input logic [1:0] dm,
                           input logic [1:0] w, input logic [15:0] s, input logic [15:0] t,
                           input logic [15:0] l);
        cfg_dir = d; cfg_src_mode = sm; cfg_dst_mode = dm; cfg_width = w;
        cfg_src_start = s; cfg_dst_start = t; cfg_len = l;
    endtask

    // pulse the trigger; returns at the negedge after the sampling edge
    task automatic fire();
        @(negedge clk); trig_set = 1'b1;
        @(negedge clk); trig_set = 1'b0;
    endtask

    task automatic pulse_soft_rst();
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
    endtask

    task automatic run_to_done(output int units, output int first_rd, output int rd_sz);
        bit seen = 0;
        units = 0; first_rd = -1; rd_sz = -1;
        for (int k = 0; k < 200; k++) begin
            if (bus_req && !bus_wr && !seen) begin
                first_rd = bus_addr; rd_sz = bus_size; seen = 1;
            end
            if (bus_req && bus_wr && bus_gnt) units++;
            if (ev_done) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not end, actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int u, fr, fs;
        bit half_seen, wrap_seen;
        int rb;
        rst = 1'b1; cfg_enable = 1'b1; trig_set = 1'b0; soft_rst = 1'b0;
        periph_req = 1'b1; bus_gnt = 1'b1; bus_err = 1'b0;
        set_cfg(2'd0, 2'd0, 2'd0, 2'd0, 16'h0, 16'h0, 16'd0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", "run_flag", run_flag, 0);
        chk("R1", "locked", locked, 0);
        chk("R1", "rst_busy", rst_busy, 0);
        chk("R1", "bus_req", bus_req, 0);
        chk("R1", "cur_src", cur_src, 0);
        chk("R1", "cur_dst", cur_dst, 0);
        chk("R1", "cur_cnt", cur_cnt, 0);

        // R2 R3 R4 R5 R6 table of transfers
        for (int v = 0; v < NV; v++) begin
            set_cfg(VECS[v].dir, VECS[v].sm, VECS[v].dm, VECS[v].wd,
                    VECS[v].src, VECS[v].dst, VECS[v].len);
            fire();
            chk("R2", "run_flag after trigger", run_flag, 1);
            run_to_done(u, fr, fs);
            chk("R2", "first read address", fr, VECS[v].src);
            chk("R3", "read size code", fs, VECS[v].szc);
            chk("R4", "units moved", u, VECS[v].units);
            chk("R5", "final source", cur_src, VECS[v].fsrc);
            chk("R5", "final destination", cur_dst, VECS[v].fdst);
            chk("R6", "done pulse", ev_done, 1);
            chk("R6", "run_flag cleared", run_flag, 0);
            chk("R4", "count at zero", cur_cnt, 0);
            @(negedge clk);
            chk("R6", "done is one cycle", ev_done, 0);
        end

        // R6 zero-length trigger
        set_cfg(2'd0, 2'd0, 2'd0, 2'd0, 16'h0, 16'h0, 16'd0);
        fire();
        chk("R6", "zero length done", ev_done, 1);
        chk("R6", "zero length idle", run_flag, 0);

        // R2 trigger ignored while disabled
        set_cfg(2'd0, 2'd0, 2'd0, 2'd0, 16'h0A00, 16'h0B00, 16'd8);
        cfg_enable = 1'b0;
        fire();
        chk("R2", "disabled trigger run_flag", run_flag, 0);
        chk("R2", "disabled trigger bus_req", bus_req, 0);
        cfg_enable = 1'b1;

        // R7 R8 wrap with half-way point, then R10 disable ends it
        set_cfg(2'd0, 2'd3, 2'd0, 2'd0, 16'h0700, 16'h0800, 16'd8);
        fire();
        half_seen = 0; wrap_seen = 0;
        for (int k = 0; k < 60; k++) begin
            if (ev_half) half_seen = 1;
            if (ev_wrap) begin wrap_seen = 1; break; end
            @(negedge clk);
        end
        chk("R7", "wrap pulse seen", wrap_seen, 1);
        chk("R8", "half pulse before wrap", half_seen, 1);
        chk("R7", "source reloaded", cur_src, 16'h0700);
        chk("R7", "destination reloaded", cur_dst, 16'h0800);
        chk("R7", "count reloaded", cur_cnt, 8);
        chk("R7", "still running", run_flag, 1);
        chk("R7", "next pass reads source start", bus_addr, 16'h0700);
        cfg_enable = 1'b0;
        #1;
        chk("R10", "request drops at once", bus_req, 0);
        @(negedge clk);
        chk("R10", "idle after disable", run_flag, 0);
        chk("R10", "no done on disable", ev_done, 0);
        cfg_enable = 1'b1;

        // R10 pending write is dropped
        set_cfg(2'd0, 2'd0, 2'd0, 2'd0, 16'h0900, 16'h0A00, 16'd8);
        bus_gnt = 1'b0;
        fire();
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        chk("R3", "write beat follows read", bus_wr, 1);
        chk("R3", "write beat address", bus_addr, 16'h0A00);
        cfg_enable = 1'b0;
        @(negedge clk);
        chk("R10", "idle with pending write", run_flag, 0);
        chk("R10", "destination untouched", cur_dst, 16'h0A00);
        chk("R5", "source stepped once", cur_src, 16'h0904);
        cfg_enable = 1'b1; bus_gnt = 1'b1;

        // R9 peripheral-to-memory read waits for periph_req
        set_cfg(2'd1, 2'd0, 2'd0, 2'd1, 16'h0C00, 16'h0D00, 16'd1);
        periph_req = 1'b0;
        fire();
        @(negedge clk); @(negedge clk);
        chk("R9", "read held without periph_req", bus_req, 0);
        periph_req = 1'b1;
        #1;
        chk("R9", "read issued with periph_req", bus_req, 1);
        @(negedge clk);
        periph_req = 1'b0;
        #1;
        chk("R9", "write not gated in p2m", bus_req & bus_wr, 1);
        periph_req = 1'b1;
        run_to_done(u, fr, fs);
        chk("R9", "p2m finishes", ev_done, 1);

        // R9 memory-to-peripheral write waits for periph_req
        set_cfg(2'd2, 2'd0, 2'd0, 2'd1, 16'h0C00, 16'h0D00, 16'd1);
        periph_req = 1'b0;
        fire();
        chk("R9", "read not gated in m2p", bus_req & ~bus_wr, 1);
        @(negedge clk);
        chk("R9", "write held without periph_req", bus_req, 0);
        chk("R9", "in write phase", bus_wr, 1);
        periph_req = 1'b1;
        run_to_done(u, fr, fs);
        chk("R9", "m2p finishes", ev_done, 1);

        // R11 bus error locks the channel
        set_cfg(2'd0, 2'd0, 2'd0, 2'd0, 16'h0E00, 16'h0F00, 16'd8);
        @(negedge clk); trig_set = 1'b1;
        @(negedge clk); trig_set = 1'b0; bus_err = 1'b1;
        @(negedge clk); bus_err = 1'b0;
        chk("R11", "abort pulse", ev_abort, 1);
        chk("R11", "idle after error", run_flag, 0);
        chk("R11", "locked", locked, 1);
        fire();
        chk("R11", "trigger ignored while locked", run_flag, 0);

        // R12 software reset window, then trigger works again
        pulse_soft_rst();
        rb = 0;
        for (int k = 0; k < 10; k++) begin
            if (rst_busy) rb++;
            if (enable_clear != rst_busy) chk("R12", "enable_clear tracks window", enable_clear, rst_busy);
            @(negedge clk);
        end
        chk("R12", "reset window length", rb, RC);
        chk("R12", "lock cleared", locked, 0);
        fire();
        chk("R12", "trigger accepted after reset", run_flag, 1);
        run_to_done(u, fr, fs);
        chk("R12", "transfer completes after reset", u, 2);

        // R12 reset in the middle of a run clears pointers; trigger ignored in window
        set_cfg(2'd0, 2'd0, 2'd0, 2'd0, 16'h1100, 16'h1200, 16'd16);
        bus_gnt = 1'b0;
        fire();
        pulse_soft_rst();
        chk("R12", "idle after reset", run_flag, 0);
        chk("R12", "source cleared", cur_src, 0);
        chk("R12", "destination cleared", cur_dst, 0);
        chk("R12", "count cleared", cur_cnt, 0);
        bus_gnt = 1'b1;
        fire();
        chk("R12", "trigger ignored in window", run_flag, 0);
        repeat (RC + 1) @(negedge clk);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule